// File: doc/BRIEF.md
# Tick-Driven Count/Compare Timer with Cause Register

This block keeps a 32-bit counter that advances by one on each cycle where an external divider raises a tick enable. Software can read and write three registers through a simple write strobe and register select: the counter itself, a compare value, and a cause register. The cause register holds a freeze bit that stops the counter, two software interrupt request bits, and a timer-pending flag.

When a tick takes the counter onto the compare value, the timer-pending flag is set and one of eight interrupt lines, chosen by a 3-bit line index, is raised. The line stays raised until software writes the compare register, which also serves as the acknowledge. The counter wraps modulo 2^32. Two further features are selected by parameters. The first makes the freeze bit writable and exposes the pending flag in the cause register. The second makes one cause bit clear-only.

Register select encoding is 0 for the counter, 1 for compare, 2 for cause. A write with select 3 is ignored. Cause bit positions: 8 and 9 are the software requests, 22 is the clear-only bit, 23 is a plain stored bit, 27 is the freeze bit, and 30 is the pending flag.

Top module: `tick_compare_timer`

## Requirements
- R1: A write to the cause register (select 2) changes only bits 8, 9, 22, 23 and 27. The other bits, including bit 30, are not affected by the write. A write with select 3 changes no register.
- R2: With the clear-only option enabled, writing 1 to cause bit 22 leaves it unchanged, and writing 0 clears it.
- R3: While cause bit 27 is 1, ticks do not advance the counter and the counter reads its frozen value. Once the bit is cleared, counting resumes from that value.
- R4: A tick that takes the counter to the compare value sets cause bit 30 and raises `irqLines[lineSel]` at the same clock edge. No other line is raised.
- R5: A compare write (select 1) clears cause bit 30 and lowers every interrupt line at the next edge.
- R6: A counter write (select 0) loads the value directly. A write that makes the counter equal to compare does not fire; only a tick can.
- R7: `softIrq[0]` and `softIrq[1]` always equal cause bits 8 and 9.
- R8: The counter wraps from 0xFFFFFFFF to 0, so a compare value below the current count fires after the wrap.
- R9: Once set, the pending flag and its line stay asserted through further ticks until compare is written. Changing `lineSel` moves the asserted line.
- R10: After reset the counter, compare and cause registers read 0 and no interrupt line is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable from the divider |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 counter, 1 compare, 2 cause |
| regWrData | input | 32 | Write data |
| lineSel | input | 3 | Index of the line that carries the timer interrupt |
| rdCount | output | 32 | Counter value |
| rdCompare | output | 32 | Compare value |
| rdCause | output | 32 | Cause register value |
| irqLines | output | 8 | Interrupt lines |
| softIrq | output | 2 | Software interrupt requests |

## Verification
Each register write and each tick takes effect at the first clock edge it is presented to. The counter, the compare value, the cause bits and the pending flag are all visible one edge after the stimulus. `irqLines` follows `lineSel` within the same cycle, with no added register stage. The bench drives inputs on the falling edge, holds each one for exactly one rising edge, and samples at the next falling edge. As a result, every expected value is compared in the cycle right after the edge that should produce it. Match checks also sample one tick before the expected firing, to confirm the flag is not raised early.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_CAUSE   = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int BIT_SOFT0  = 8;
  localparam int BIT_SOFT1  = 9;
  localparam int BIT_CLRONL = 22;
  localparam int BIT_PLAIN  = 23;
  localparam int BIT_FREEZE = 27;
  localparam int BIT_PEND   = 30;

  typedef struct packed {
    logic loadCount;
    logic incCount;
    logic loadCompare;
    logic loadCause;
    logic setPend;
    logic clrPend;
  } tct_strobe_t;
endpackage

// File: rtl/tct_control.sv
module tct_control
  import tct_pkg::*;
(
  input  logic        tickEn,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic        freezeBit,
  input  logic        hitOnInc,
  output tct_strobe_t strobes
);
  logic wrCount, wrCompare, wrCause;

  always_comb begin
    wrCount   = regWrEn && (regSel == SEL_COUNT);
    wrCompare = regWrEn && (regSel == SEL_COMPARE);
    wrCause   = regWrEn && (regSel == SEL_CAUSE);

    strobes             = '0;
    strobes.loadCount   = wrCount;
    strobes.incCount    = tickEn && !freezeBit && !wrCount;
    strobes.loadCompare = wrCompare;
    strobes.loadCause   = wrCause;
    // acknowledge wins over a coincident match
    strobes.clrPend     = wrCompare;
    strobes.setPend     = tickEn && !freezeBit && !wrCount && !wrCompare && hitOnInc;
  end
endmodule

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_LINES = 8,
  parameter bit REV2_EN   = 1'b1,
  parameter bit REV6_EN   = 1'b1,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tct_strobe_t          strobes,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [SEL_W-1:0]     lineSel,
  output logic [CNT_W-1:0]     countQ,
  output logic [CNT_W-1:0]     compareQ,
  output logic [CNT_W-1:0]     causeView,
  output logic                 freezeBit,
  output logic                 hitOnInc,
  output logic [NUM_LINES-1:0] irqVec,
  output logic [1:0]           softVec
);
  localparam logic [CNT_W-1:0] BASE_MASK =
      (CNT_W'(1) << BIT_SOFT0) | (CNT_W'(1) << BIT_SOFT1) |
      (CNT_W'(1) << BIT_CLRONL) | (CNT_W'(1) << BIT_PLAIN);
  localparam logic [CNT_W-1:0] FREEZE_MASK = CNT_W'(1) << BIT_FREEZE;
  localparam logic [CNT_W-1:0] FULL_MASK = REV2_EN ? (BASE_MASK | FREEZE_MASK) : BASE_MASK;

  logic [CNT_W-1:0] causeQ;
  logic [CNT_W-1:0] countInc;
  logic [CNT_W-1:0] wrMask;
  logic             pendQ;

  assign countInc = countQ + CNT_W'(1);
  assign hitOnInc = (countInc == compareQ);

  generate
    if (REV6_EN) begin : g_clr_only
      assign wrMask = FULL_MASK & ~(wrData & (CNT_W'(1) << BIT_CLRONL));
    end else begin : g_plain
      assign wrMask = FULL_MASK;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      compareQ <= '0;
      causeQ   <= '0;
      pendQ    <= 1'b0;
    end else begin
      if (strobes.loadCount)      countQ <= wrData;
      else if (strobes.incCount)  countQ <= countInc;
      if (strobes.loadCompare)    compareQ <= wrData;
      if (strobes.loadCause)      causeQ <= (causeQ & ~wrMask) | (wrData & wrMask);
      if (strobes.clrPend)        pendQ <= 1'b0;
      else if (strobes.setPend)   pendQ <= 1'b1;
    end
  end

  always_comb begin
    causeView = causeQ;
    causeView[BIT_PEND] = REV2_EN ? pendQ : 1'b0;
  end

  assign freezeBit = causeQ[BIT_FREEZE];
  assign softVec   = {causeQ[BIT_SOFT1], causeQ[BIT_SOFT0]};

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign irqVec[i] = pendQ && (lineSel == SEL_W'(i));
    end
  endgenerate
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tct_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_LINES = 8,
  parameter bit REV2_EN   = 1'b1,
  parameter bit REV6_EN   = 1'b1,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [CNT_W-1:0]     regWrData,
  input  logic [SEL_W-1:0]     lineSel,
  output logic [CNT_W-1:0]     rdCount,
  output logic [CNT_W-1:0]     rdCompare,
  output logic [CNT_W-1:0]     rdCause,
  output logic [NUM_LINES-1:0] irqLines,
  output logic [1:0]           softIrq
);
  tct_strobe_t strobes;
  logic        freezeBit;
  logic        hitOnInc;

  tct_control u_ctrl (
    .tickEn    (tickEn),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .freezeBit (freezeBit),
    .hitOnInc  (hitOnInc),
    .strobes   (strobes)
  );

  tct_datapath #(
    .CNT_W     (CNT_W),
    .NUM_LINES (NUM_LINES),
    .REV2_EN   (REV2_EN),
    .REV6_EN   (REV6_EN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .lineSel   (lineSel),
    .countQ    (rdCount),
    .compareQ  (rdCompare),
    .causeView (rdCause),
    .freezeBit (freezeBit),
    .hitOnInc  (hitOnInc),
    .irqVec    (irqLines),
    .softVec   (softIrq)
  );
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int CNT_W     = 32,
  parameter int NUM_LINES = 8,
  parameter bit REV6_EN   = 1'b1,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [1:0]           regSel,
  input logic [CNT_W-1:0]     regWrData,
  input logic [CNT_W-1:0]     rdCount,
  input logic [CNT_W-1:0]     rdCause,
  input logic [NUM_LINES-1:0] irqLines,
  input logic [1:0]           softIrq
);
  logic cntWr, cmpWr;
  assign cntWr = regWrEn && (regSel == 2'd0);
  assign cmpWr = regWrEn && (regSel == 2'd1);

  AST_LINE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines)); // R4

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdCause[27] && !cntWr) |=> (rdCount == $past(rdCount))); // R3

  AST_COMPARE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    cmpWr |=> (irqLines == '0 && !rdCause[30])); // R5

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (rdCount == $past(regWrData))); // R6

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rdCause[30] && !cmpWr) |=> rdCause[30]); // R9

  AST_SOFT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    softIrq == rdCause[9:8]); // R7

  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (REV6_EN && !rdCause[22]) |=> !rdCause[22]); // R2
endmodule

bind tick_compare_timer tct_checker #(
  .CNT_W     (CNT_W),
  .NUM_LINES (NUM_LINES),
  .REV6_EN   (REV6_EN)
) u_tct_checker (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .rdCount   (rdCount),
  .rdCause   (rdCause),
  .irqLines  (irqLines),
  .softIrq   (softIrq)
);

// File: tb/tb_tick_compare_timer.sv
`timescale 1ns/1ps
module tb_tick_compare_timer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic        regWrEn;
  logic [1:0]  regSel;
  logic [31:0] regWrData;
  logic [2:0]  lineSel;
  logic [31:0] rdCount, rdCompare, rdCause;
  logic [7:0]  irqLines;
  logic [1:0]  softIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_compare_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .lineSel(lineSel),
    .rdCount(rdCount), .rdCompare(rdCompare), .rdCause(rdCause),
    .irqLines(irqLines), .softIrq(softIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 2'd0; regWrData = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
    end
    tickEn = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, expCause;
    rstN = 1'b0; tickEn = 1'b0; regWrEn = 1'b0; regSel = 2'd0;
    regWrData = '0; lineSel = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 count", rdCount, 32'h0);
    chk("R10 compare", rdCompare, 32'h0);
    chk("R10 cause", rdCause, 32'h0);
    chk("R10 irq", {24'h0, irqLines}, 32'h0);

    // R1 R2 R7: walking one through every cause bit
    expCause = '0;
    for (int b = 0; b < 32; b++) begin
      d = 32'h1 << b;
      wr(2'd2, d);
      expCause = d & 32'h08800300; // bit 22 never set by a write
      chk($sformatf("R1 walk bit %0d", b), rdCause, expCause);
      chk("R7 soft", {30'h0, softIrq}, {30'h0, expCause[9:8]});
    end
    wr(2'd2, 32'hFFFFFFFF);
    chk("R2 bit22 set ignored", {31'h0, rdCause[22]}, 32'h0);
    chk("R1 all ones", rdCause, 32'h08800300);
    wr(2'd3, 32'h0);
    chk("R1 select3 ignored cause", rdCause, 32'h08800300);
    chk("R1 select3 ignored count", rdCount, 32'h0);
    wr(2'd2, 32'h00000100);
    chk("R7 soft0 only", {30'h0, softIrq}, 32'h1);
    wr(2'd2, 32'h0);
    chk("R7 soft cleared", {30'h0, softIrq}, 32'h0);

    // R4 R5 R9: sweep every line index
    for (int l = 0; l < 8; l++) begin
      lineSel = 3'(l);
      wr(2'd0, 32'h100 * l);
      wr(2'd1, 32'h100 * l + 3);
      ticks(2);
      chk($sformatf("R4 early line %0d", l), {24'h0, irqLines}, 32'h0);
      ticks(1);
      chk($sformatf("R4 fire line %0d", l), {24'h0, irqLines}, 32'h1 << l);
      chk("R4 pend bit", {31'h0, rdCause[30]}, 32'h1);
      chk("R4 count at compare", rdCount, 32'h100 * l + 3);
      ticks(4);
      chk("R9 held", {24'h0, irqLines}, 32'h1 << l);
      lineSel = 3'((l + 1) % 8);
      #1;
      chk("R9 line moves", {24'h0, irqLines}, 32'h1 << ((l + 1) % 8));
      wr(2'd1, 32'h0);
      chk("R5 ack irq", {24'h0, irqLines}, 32'h0);
      chk("R5 ack pend", {31'h0, rdCause[30]}, 32'h0);
    end

    // R8 wrap
    lineSel = 3'd5;
    wr(2'd0, 32'hFFFFFFFE);
    wr(2'd1, 32'h00000001);
    ticks(2);
    chk("R8 wrapped count", rdCount, 32'h0);
    chk("R8 not yet", {24'h0, irqLines}, 32'h0);
    ticks(1);
    chk("R8 fire after wrap", {24'h0, irqLines}, 32'h20);

    // R6 count write equal to compare does not fire
    wr(2'd1, 32'h55);
    wr(2'd0, 32'h55);
    chk("R6 load", rdCount, 32'h55);
    chk("R6 no fire on load", {24'h0, irqLines}, 32'h0);
    ticks(1);
    chk("R6 counts from loaded", rdCount, 32'h56);

    // R3 freeze
    wr(2'd1, 32'h60);
    wr(2'd0, 32'h5F);
    wr(2'd2, 32'h08000000);
    ticks(5);
    chk("R3 frozen", rdCount, 32'h5F);
    chk("R3 no match when frozen", {24'h0, irqLines}, 32'h0);
    wr(2'd0, 32'h5E);
    chk("R3 load while frozen", rdCount, 32'h5E);
    wr(2'd2, 32'h0);
    ticks(1);
    chk("R3 resume", rdCount, 32'h5F);
    ticks(1);
    chk("R3 match after resume", {24'h0, irqLines}, 32'h20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule